// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block keeps subroutine return addresses for a small 8-bit microcontroller core. It has exactly two storage levels and no stack pointer. A call strobe arrives together with the program counter already incremented by one. That address becomes the new top entry, and the entry it replaces moves down one level. A return strobe presents the top entry to the program counter in the same cycle. The lower entry then moves up into the top.

Overflow and underflow are silent and follow fixed shifting rules. A third nested call pushes out the oldest address. Repeated returns keep supplying whatever address sat in the lower level, because that level is never cleared by a pop. The entry width is a parameter: 9 bits for the smallest core and 11 bits for the larger ones. Each entry holds the full program counter, so a return needs no page fix-up.

Top module: `retStack2`

## Requirements
- R1: After synchronous reset, both levels hold zero. The top output reads zero, and it still reads zero after one further return.
- R2: A cycle with only the call strobe asserted writes the pushed address into the top level. The top output shows it from the next cycle.
- R3: On a call-only cycle, the previous top value moves into the lower level, so a later return exposes it again.
- R4: After more than two calls in a row, only the two most recent addresses remain. Older addresses are lost.
- R5: The top output is combinational from the top level. It carries the return address during the same cycle as the return strobe.
- R6: A return-only cycle copies the lower level into the top and leaves the lower level unchanged. Every further return keeps yielding that same address.
- R7: When call and return are asserted together, the return is serviced first. The output in that cycle is the old top. Afterwards the top holds the pushed address and the lower level keeps its previous value.
- R8: With neither strobe asserted, both levels hold their values.
- R9: Every bit of the configured width is stored and returned, including the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| callStrobe | input | 1 | Push request for one cycle |
| returnStrobe | input | 1 | Pop request for one cycle |
| pushAddr | input | ADDR_W | Incremented program counter to store on a call |
| topOfStack | output | ADDR_W | Current top-level entry, valid combinationally |

## Verification
Call and return are the two functions that can land in the same cycle. The bench provokes this overlap with an empty stack, with a full stack, and right after an overflow. In each case it checks that the output in that cycle is the old top. It then checks that the pushed address sits on top and that the lower level is unchanged, by issuing further returns. A behavioural two-entry queue model, with pop applied before push, is compared to the top output on every clock.

// File: rtl/retStack2_pkg.sv
package retStack2_pkg;
  // Strobes issued by the sequencer to the storage datapath.
  typedef struct packed {
    logic pushTop;    // top level takes the pushed address
    logic shiftDown;  // lower level takes the current top
    logic popUp;      // top level takes the lower level
  } stackCtl_t;
endpackage

// File: rtl/retStack2_ctrl.sv
module retStack2_ctrl
  import retStack2_pkg::*;
(
  input  logic      callStrobe,
  input  logic      returnStrobe,
  output stackCtl_t ctl
);
  logic bothReq;

  always_comb begin
    bothReq       = callStrobe && returnStrobe;
    ctl.pushTop   = callStrobe;
    // Pop-then-push: lower level gets the popped top's replacement (itself).
    ctl.shiftDown = callStrobe && !bothReq;
    ctl.popUp     = returnStrobe && !bothReq;
  end

  // R7: a combined request never moves the lower level
  always_comb begin
    if (bothReq) begin
      a_both_noshift_r7: assert (!ctl.shiftDown && !ctl.popUp);
    end
  end
endmodule

// File: rtl/retStack2_dp.sv
module retStack2_dp
  import retStack2_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  stackCtl_t         ctl,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic [ADDR_W-1:0] levelTop
);
  localparam logic [ADDR_W-1:0] RESET_VAL = '0;

  logic [ADDR_W-1:0] levelLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      levelTop <= RESET_VAL;
      levelLow <= RESET_VAL;
    end else begin
      if (ctl.pushTop)        levelTop <= pushAddr;
      else if (ctl.popUp)     levelTop <= levelLow;
      if (ctl.shiftDown)      levelLow <= levelTop;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (levelTop == '0 && levelLow == '0));

  p_push_top_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.pushTop |=> levelTop == $past(pushAddr));

  p_shift_low_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftDown |=> levelLow == $past(levelTop));

  p_pop_keep_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.popUp |=> (levelTop == $past(levelLow) && $stable(levelLow)));

  p_both_low_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.pushTop && !ctl.shiftDown) |=> $stable(levelLow));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl == '0) |=> ($stable(levelTop) && $stable(levelLow)));
endmodule

// File: rtl/retStack2.sv
module retStack2
  import retStack2_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              callStrobe,
  input  logic              returnStrobe,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic [ADDR_W-1:0] topOfStack
);
  stackCtl_t ctl;

  retStack2_ctrl i_ctrl (
    .callStrobe  (callStrobe),
    .returnStrobe(returnStrobe),
    .ctl         (ctl)
  );

  retStack2_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .pushAddr(pushAddr),
    .levelTop(topOfStack)
  );
endmodule

// File: tb/test_retStack2.sv
`timescale 1ns/1ps
module test_retStack2;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic callStrobe = 1'b0;
  logic returnStrobe = 1'b0;
  logic [W-1:0] pushAddr = '0;
  logic [W-1:0] topOfStack;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int model[2];

  always #5 clk = ~clk;

  retStack2 #(.ADDR_W(W)) i_retStack2 (
    .clk(clk), .rst(rst), .callStrobe(callStrobe),
    .returnStrobe(returnStrobe), .pushAddr(pushAddr),
    .topOfStack(topOfStack)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check output mid-cycle, update model at edge.
  task automatic cyc(input bit c, input bit r, input int a, input string req);
    callStrobe = c; returnStrobe = r; pushAddr = W'(a);
    #1;
    check(req, int'(topOfStack), model[0]);
    @(posedge clk);
    if (r) model[0] = model[1];
    if (c) begin model[1] = model[0]; model[0] = a; end
    @(negedge clk);
  endtask

  task automatic expectTop(input int exp, input string req);
    #1;
    check(req, int'(topOfStack), exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model[0] = 0; model[1] = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    expectTop(0, "R1 reset top");
    cyc(0, 1, 0, "R1 return after reset");
    expectTop(0, "R1 lower level zero");
    // R2/R3: two calls, two returns
    cyc(1, 0, 11'h123, "R2 call 1");
    expectTop(11'h123, "R2 top after call");
    cyc(1, 0, 11'h456, "R3 call 2");
    cyc(0, 1, 0, "R5 return gives second");
    expectTop(11'h123, "R3 first address moved down");
    cyc(0, 1, 0, "R6 return gives first");
    cyc(0, 1, 0, "R6 repeated return");
    expectTop(11'h123, "R6 lower level retained");
    // R4 overflow and R9 full width
    cyc(1, 0, 11'h7FF, "R9 call msb");
    cyc(1, 0, 11'h401, "R4 call b");
    cyc(1, 0, 11'h402, "R4 call c");
    cyc(0, 0, 0, "R8 idle");
    cyc(0, 0, 0, "R8 idle again");
    expectTop(11'h402, "R8 top held");
    cyc(0, 1, 0, "R4 pop c");
    expectTop(11'h401, "R4 second newest");
    cyc(0, 1, 0, "R4 pop b");
    expectTop(11'h401, "R4 oldest lost");
    // R7 simultaneous cases
    cyc(1, 1, 11'h0AA, "R7 both, old top out");
    expectTop(11'h0AA, "R7 pushed on top");
    cyc(0, 1, 0, "R7 return pushed");
    expectTop(11'h401, "R7 lower unchanged");
    cyc(1, 0, 11'h7F0, "R9 call");
    cyc(1, 0, 11'h60F, "R9 call full");
    cyc(1, 1, 11'h155, "R7 both on full stack");
    cyc(0, 1, 0, "R7 pop after both");
    expectTop(11'h7F0, "R7 full stack lower kept");
    cyc(0, 1, 0, "R9 msb returned");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model[0] = 0; model[1] = 0;
    expectTop(0, "R1 reset clears");
    cyc(1, 1, 11'h333, "R7 both on empty");
    cyc(0, 1, 0, "R7 return of pushed");
    expectTop(0, "R1 R7 lower still zero");
    for (int i = 0; i < 40; i++)
      cyc(((i % 3) != 1), ((i % 4) == 2), (i * 97 + 5) % 2048, "R4 R6 R7 mixed");
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule